// File: doc/BRIEF.md
# T1 Transmit Channel Byte Processor

This block sits in the transmit path of a 24-channel T1 framer and rewrites each outgoing channel byte before it is serialised. Every byte arrives with its channel number, its frame number within the superframe, a framing-mode flag (D4 or ESF) and the four signaling bits for that channel. Per channel, the block can replace the byte with a programmable idle pattern. It can stuff bit 7 to keep ones density on an all-zero byte, and it can rob bit 8 for signaling in the signaling frames. A per-channel clear-channel mask turns off the stuffing and the signaling. A global force-stuffing override and the D4 remote-alarm bit 2 clearing still act on clear channels.

Configuration is written through a simple byte-wide write port: three clear-channel mask registers, three idle-select mask registers, an idle pattern register and a control register. The result leaves one clock after the byte enters.

Bit numbering in this brief: bit 1 is the MSB (`data[7]`, sent first) and bit 8 is the LSB (`data[0]`). Bit 7 is `data[1]` and bit 2 is `data[6]`. Channel n (1..24) is presented as `byte_chan = n-1`.

Top module: `t1_tx_chan_proc`

## Requirements
- R1: After reset `out_valid` and `out_data` are 0 and every configuration register is 0. This means no clear channels, no idle channels, an idle pattern of 0x00, the override off and the alarm off.
- R2: `out_valid` equals `byte_valid` of the previous cycle. When no byte is accepted, `out_data` keeps its value.
- R3: Channel n is mapped to bit (n-1)%8 of a register. For the clear-channel mask that register is 0x39+(n-1)/8, and for the idle-select mask it is 0x3C+(n-1)/8. 0x3F holds the idle pattern. 0x40 is the control register: bit0 = force-stuff arm A, bit1 = force-stuff arm B, bit2 = remote alarm. A write takes effect from the next cycle, and a write to any other address changes nothing.
- R4: When a channel's idle-select bit is 1, the byte is replaced by the idle pattern. Otherwise the input byte passes.
- R5: For a non-clear channel, when the byte after idle substitution is 0x00, bit 7 (`data[1]`) is set to 1.
- R6: A clear channel gets neither bit 7 stuffing nor robbed-bit signaling.
- R7: When control bits 0 and 1 are both 1, bit 7 stuffing applies to all channels, clear or not. One of the two bits alone has no effect. Clear channels still get no signaling.
- R8: In D4 mode (`byte_esf`=0), bit 8 of a non-clear channel is replaced by A (`byte_sig[0]`) in frame 6 and by B (`byte_sig[1]`) in frame 12. No other frame is altered.
- R9: In ESF mode (`byte_esf`=1), bit 8 of a non-clear channel is replaced by A, B, C, D (`byte_sig[0..3]`) in frames 6, 12, 18 and 24 respectively.
- R10: In D4 mode with the alarm bit set, bit 2 (`data[6]`) of every channel is forced to 0, clear channels included. In ESF mode the alarm bit changes no byte.
- R11: The steps apply in this order: idle substitution, stuffing (tested on the substituted byte), signaling, then the alarm clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| byte_valid | input | 1 | Input byte present |
| byte_chan | input | 5 | Channel index, 0..23 for channels 1..24 |
| byte_frame | input | 5 | Frame number within superframe, 1..24 |
| byte_esf | input | 1 | 1 = ESF, 0 = D4 |
| byte_sig | input | 4 | Signaling bits: [0]=A, [1]=B, [2]=C, [3]=D |
| byte_data | input | 8 | Channel byte, data[7] is bit 1 |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Processed channel byte |

## Verification
Distinct data patterns tell the rewrite steps apart. All-zero bytes expose stuffing. 0xFF bytes expose the bit 2 alarm clear and the bit 8 signaling value. Bytes like 0xA5 show untouched pass-through. Frames 6, 12, 18 and 24 are walked in both modes with alternating signaling nibbles, which separates the D4 and ESF schedules. Idle patterns of 0x00 and 0x40 show that stuffing is tested after substitution but not after the alarm clear. A final sweep over all channels uses pseudo-random masks and data, and checks the channel-to-register-bit mapping against a behavioural model every cycle.

// File: rtl/t1_tx_pkg.sv
`timescale 1ns/1ps
package t1_tx_pkg;
   localparam int BYTE_W    = 8;
   localparam int FRAME_W   = 5;
   localparam int SIG_W     = 4;
   // bit n (1 = MSB) lives at index BYTE_W-n
   localparam int STUFF_IDX = BYTE_W - 7;
   localparam int ROB_IDX   = BYTE_W - 8;
   localparam int ALARM_IDX = BYTE_W - 2;

   typedef struct packed {
      logic alarm;
      logic force_b;
      logic force_a;
   } tx_ctrl_t;

   typedef enum logic [1:0] {SLOT_A = 2'd0, SLOT_B = 2'd1, SLOT_C = 2'd2, SLOT_D = 2'd3} sig_slot_e;
endpackage

// File: rtl/t1_tx_cfg_bank.sv
`timescale 1ns/1ps
module t1_tx_cfg_bank
   import t1_tx_pkg::*;
#(
   parameter int NUM_CHAN    = 24,
   parameter int ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] CLEAR_BASE = 8'h39,
   parameter logic [ADDR_W-1:0] IDLE_BASE  = 8'h3C,
   parameter logic [ADDR_W-1:0] CODE_ADDR  = 8'h3F,
   parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'h40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [NUM_CHAN-1:0] clear_mask,
   output logic [NUM_CHAN-1:0] idle_mask,
   output logic [BYTE_W-1:0]   idle_code,
   output tx_ctrl_t            ctrl
);
   localparam int GROUPS = (NUM_CHAN + BYTE_W - 1) / BYTE_W;
   localparam int FLAT_W = GROUPS * BYTE_W;

   logic [FLAT_W-1:0] clear_flat, idle_flat;

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      logic hit_clear, hit_idle;
      assign hit_clear = we && (addr == CLEAR_BASE + ADDR_W'(g));
      assign hit_idle  = we && (addr == IDLE_BASE  + ADDR_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            clear_flat[g*BYTE_W +: BYTE_W] <= '0;
            idle_flat[g*BYTE_W +: BYTE_W]  <= '0;
         end else begin
            if (hit_clear) clear_flat[g*BYTE_W +: BYTE_W] <= wdata;
            if (hit_idle)  idle_flat[g*BYTE_W +: BYTE_W]  <= wdata;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_code <= '0;
         ctrl      <= '0;
      end else if (we) begin
         if (addr == CODE_ADDR) idle_code <= wdata;
         if (addr == CTRL_ADDR) ctrl <= tx_ctrl_t'(wdata[2:0]);
      end
   end

   assign clear_mask = clear_flat[NUM_CHAN-1:0];
   assign idle_mask  = idle_flat[NUM_CHAN-1:0];

   // R3: pattern register follows the write data one cycle later
   a_r3_code_write: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == CODE_ADDR) |=> (idle_code == $past(wdata)));
   // R3: foreign addresses leave the idle pattern alone
   a_r3_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && addr == CODE_ADDR) |=> $stable(idle_code));
endmodule

// File: rtl/t1_tx_rob_sched.sv
`timescale 1ns/1ps
module t1_tx_rob_sched
   import t1_tx_pkg::*;
(
   input  logic [FRAME_W-1:0] frame,
   input  logic               esf,
   input  logic [SIG_W-1:0]   sig,
   output logic               rob_en,
   output logic               rob_bit
);
   sig_slot_e slot;

   always_comb begin
      rob_en = 1'b0;
      slot   = SLOT_A;
      unique case (frame)
         5'd6:  begin rob_en = 1'b1; slot = SLOT_A; end
         5'd12: begin rob_en = 1'b1; slot = SLOT_B; end
         5'd18: begin rob_en = esf;  slot = SLOT_C; end
         5'd24: begin rob_en = esf;  slot = SLOT_D; end
         default: ;
      endcase
      rob_bit = sig[slot];
   end
endmodule

// File: rtl/t1_tx_byte_xform.sv
`timescale 1ns/1ps
module t1_tx_byte_xform
   import t1_tx_pkg::*;
(
   input  logic [BYTE_W-1:0] raw,
   input  logic              use_idle,
   input  logic [BYTE_W-1:0] idle_code,
   input  logic              stuff_ok,
   input  logic              rob_en,
   input  logic              rob_bit,
   input  logic              alarm_clr,
   output logic [BYTE_W-1:0] result
);
   logic [BYTE_W-1:0] s_idle, s_stuff, s_rob;

   always_comb begin
      s_idle  = use_idle ? idle_code : raw;
      s_stuff = s_idle;
      if (stuff_ok && (s_idle == '0)) s_stuff[STUFF_IDX] = 1'b1;
      s_rob = s_stuff;
      if (rob_en) s_rob[ROB_IDX] = rob_bit;
      result = s_rob;
      if (alarm_clr) result[ALARM_IDX] = 1'b0;
   end
endmodule

// File: rtl/t1_tx_chan_proc.sv
`timescale 1ns/1ps
module t1_tx_chan_proc
   import t1_tx_pkg::*;
#(
   parameter int NUM_CHAN = 24,
   parameter int ADDR_W   = 8,
   localparam int CHAN_W  = $clog2(NUM_CHAN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [BYTE_W-1:0] cfg_wdata,
   input  logic              byte_valid,
   input  logic [CHAN_W-1:0] byte_chan,
   input  logic [FRAME_W-1:0] byte_frame,
   input  logic              byte_esf,
   input  logic [SIG_W-1:0]  byte_sig,
   input  logic [BYTE_W-1:0] byte_data,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_data
);
   if (NUM_CHAN < 2 || NUM_CHAN > 32) begin : g_bad_chan
      $error("t1_tx_chan_proc: NUM_CHAN out of range");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("t1_tx_chan_proc: ADDR_W too narrow for the register map");
   end

   logic [NUM_CHAN-1:0] clear_mask, idle_mask;
   logic [BYTE_W-1:0]   idle_code, next_byte;
   tx_ctrl_t            ctrl;
   logic ch_clear, ch_idle, force_all, rob_hit, rob_bit;

   t1_tx_cfg_bank #(.NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .clear_mask(clear_mask), .idle_mask(idle_mask), .idle_code(idle_code), .ctrl(ctrl));

   t1_tx_rob_sched u_sched (
      .frame(byte_frame), .esf(byte_esf), .sig(byte_sig),
      .rob_en(rob_hit), .rob_bit(rob_bit));

   assign ch_clear  = clear_mask[byte_chan];
   assign ch_idle   = idle_mask[byte_chan];
   assign force_all = ctrl.force_a & ctrl.force_b;

   t1_tx_byte_xform u_xform (
      .raw(byte_data), .use_idle(ch_idle), .idle_code(idle_code),
      .stuff_ok(!ch_clear || force_all),
      .rob_en(rob_hit && !ch_clear), .rob_bit(rob_bit),
      .alarm_clr(ctrl.alarm && !byte_esf),
      .result(next_byte));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= byte_valid;
         if (byte_valid) out_data <= next_byte;
      end
   end

   // R2: output strobe trails input strobe by one cycle
   a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |=> out_valid);
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_valid |=> (!out_valid && $stable(out_data)));
   // R10: D4 alarm clears bit 2 on every channel
   a_r10_alarm_bit2: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && !byte_esf && ctrl.alarm) |=> !out_data[ALARM_IDX]);
   // R5: all-zero byte on a non-clear, non-idle channel leaves with bit 7 set
   a_r5_stuff_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && !ch_clear && !ch_idle && byte_data == '0) |=> out_data[STUFF_IDX]);
   // R6: clear channel, no idle, no override, no alarm -> untouched
   a_r6_clear_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && ch_clear && !ch_idle && !force_all && !(ctrl.alarm && !byte_esf))
      |=> (out_data == $past(byte_data)));
   // input contract: channel index within range
   a_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |-> (int'(byte_chan) < NUM_CHAN));
endmodule

// File: tb/tb_t1_tx_chan_proc.sv
`timescale 1ns/1ps
module tb_t1_tx_chan_proc;
   logic clk = 0, rst_n = 0;
   logic cfg_we = 0;
   logic [7:0] cfg_addr = 0, cfg_wdata = 0;
   logic byte_valid = 0, byte_esf = 0;
   logic [4:0] byte_chan = 0, byte_frame = 1;
   logic [3:0] byte_sig = 0;
   logic [7:0] byte_data = 0;
   logic out_valid;
   logic [7:0] out_data;

   int n_checks = 0, n_fail = 0;
   bit done = 0;

   // behavioural model state
   bit m_clear[24], m_idle[24];
   bit [7:0] m_code = 0;
   bit m_fa = 0, m_fb = 0, m_alarm = 0;
   bit exp_valid = 0;
   bit [7:0] exp_data = 0;
   int unsigned lcg = 32'h1234_5678;

   t1_tx_chan_proc dut (.*);

   always #2 clk = ~clk;

   function automatic int idx(int n); return 8 - n; endfunction

   function automatic bit [7:0] model(bit [7:0] d, int ch, int fr, bit esf, bit [3:0] sg);
      bit [7:0] b = m_idle[ch] ? m_code : d;
      if ((!m_clear[ch] || (m_fa && m_fb)) && b == 8'h00) b[idx(7)] = 1;
      if (!m_clear[ch]) begin
         if (fr == 6) b[idx(8)] = sg[0];
         else if (fr == 12) b[idx(8)] = sg[1];
         else if (esf && fr == 18) b[idx(8)] = sg[2];
         else if (esf && fr == 24) b[idx(8)] = sg[3];
      end
      if (!esf && m_alarm) b[idx(2)] = 0;
      return b;
   endfunction

   task automatic check(string tag, bit [7:0] act, bit [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic step(string tag);
      @(posedge clk);
      exp_valid = byte_valid;
      if (byte_valid) exp_data = model(byte_data, byte_chan, byte_frame, byte_esf, byte_sig);
      if (cfg_we) begin
         if (cfg_addr >= 8'h39 && cfg_addr <= 8'h3B)
            for (int k = 0; k < 8; k++) m_clear[(cfg_addr-8'h39)*8+k] = cfg_wdata[k];
         else if (cfg_addr >= 8'h3C && cfg_addr <= 8'h3E)
            for (int k = 0; k < 8; k++) m_idle[(cfg_addr-8'h3C)*8+k] = cfg_wdata[k];
         else if (cfg_addr == 8'h3F) m_code = cfg_wdata;
         else if (cfg_addr == 8'h40) begin
            m_fa = cfg_wdata[0]; m_fb = cfg_wdata[1]; m_alarm = cfg_wdata[2];
         end
      end
      #1;
      check({tag, " valid"}, {7'd0, out_valid}, {7'd0, exp_valid});
      check(tag, out_data, exp_data);
      cfg_we = 0; byte_valid = 0;
   endtask

   task automatic wr(bit [7:0] a, bit [7:0] d);
      cfg_we = 1; cfg_addr = a; cfg_wdata = d;
      step("R3 write");
   endtask

   task automatic send(string tag, int ch, int fr, bit esf, bit [3:0] sg, bit [7:0] d);
      byte_valid = 1; byte_chan = 5'(ch - 1); byte_frame = 5'(fr);
      byte_esf = esf; byte_sig = sg; byte_data = d;
      step(tag);
   endtask

   task automatic expect_byte(string tag, bit [7:0] want);
      check({tag, " direct"}, out_data, want);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      check("R1 reset valid", {7'd0, out_valid}, 8'd0);
      check("R1 reset data", out_data, 8'h00);

      send("R1", 1, 1, 0, 0, 8'h00); expect_byte("R1", 8'h02);
      send("R1", 2, 1, 0, 0, 8'hA5); expect_byte("R1", 8'hA5);
      repeat (3) step("R2 hold"); expect_byte("R2", 8'hA5);

      // R3 mapping: ch9 -> 0x3A bit0; same-cycle byte sees old state
      cfg_we = 1; cfg_addr = 8'h3A; cfg_wdata = 8'h01;
      send("R3 old", 9, 1, 0, 0, 8'h00); expect_byte("R3 old", 8'h02);
      send("R3", 9, 1, 0, 0, 8'h00); expect_byte("R3", 8'h00);
      send("R3", 8, 1, 0, 0, 8'h00); expect_byte("R3", 8'h02);
      wr(8'h41, 8'hFF); wr(8'h38, 8'hFF);
      send("R3 ignore", 8, 1, 0, 0, 8'hFF); expect_byte("R3 ignore", 8'hFF);

      // R4 idle on ch17 -> 0x3E bit0
      wr(8'h3F, 8'h7E); wr(8'h3E, 8'h01);
      send("R4", 17, 1, 0, 0, 8'h11); expect_byte("R4", 8'h7E);
      send("R4", 16, 1, 0, 0, 8'h11); expect_byte("R4", 8'h11);
      wr(8'h3F, 8'h00);
      send("R5 idle zero", 17, 1, 0, 0, 8'hFF); expect_byte("R5", 8'h02);

      // R6 clear ch9 in signaling frame
      send("R6", 9, 6, 0, 4'h0, 8'hFF); expect_byte("R6", 8'hFF);
      send("R6", 9, 12, 1, 4'h0, 8'h00); expect_byte("R6", 8'h00);

      // R7 override
      wr(8'h40, 8'h01);
      send("R7 one arm", 9, 1, 0, 0, 8'h00); expect_byte("R7", 8'h00);
      wr(8'h40, 8'h02);
      send("R7 one arm", 9, 1, 0, 0, 8'h00); expect_byte("R7", 8'h00);
      wr(8'h40, 8'h03);
      send("R7", 9, 1, 0, 0, 8'h00); expect_byte("R7", 8'h02);
      send("R7 nosig", 9, 6, 0, 4'h0, 8'h00); expect_byte("R7", 8'h02);
      wr(8'h40, 8'h00);

      // R8 D4 schedule
      send("R8", 3, 6, 0, 4'b1110, 8'hFF); expect_byte("R8", 8'hFE);
      send("R8", 3, 12, 0, 4'b0001, 8'hFF); expect_byte("R8", 8'hFE);
      send("R8", 3, 18, 0, 4'b0000, 8'hFF); expect_byte("R8", 8'hFF);
      send("R8", 3, 24, 0, 4'b0000, 8'hFF); expect_byte("R8", 8'hFF);
      send("R8", 3, 5, 0, 4'b0000, 8'hFF); expect_byte("R8", 8'hFF);
      // R9 ESF schedule
      send("R9", 4, 6, 1, 4'b1110, 8'h00); expect_byte("R9", 8'h02);
      send("R9", 4, 12, 1, 4'b0010, 8'h00); expect_byte("R9", 8'h03);
      send("R9", 4, 18, 1, 4'b1011, 8'hFF); expect_byte("R9", 8'hFE);
      send("R9", 4, 24, 1, 4'b1000, 8'h00); expect_byte("R9", 8'h03);

      // R10 alarm
      wr(8'h40, 8'h04);
      send("R10", 5, 1, 0, 0, 8'hFF); expect_byte("R10", 8'hBF);
      send("R10 clear", 9, 1, 0, 0, 8'hFF); expect_byte("R10", 8'hBF);
      send("R10 esf", 5, 1, 1, 0, 8'hFF); expect_byte("R10", 8'hFF);
      // R11 ordering: idle 0x40 then alarm -> 0x00, no re-stuff
      wr(8'h3F, 8'h40); wr(8'h3C, 8'h10);
      send("R11", 5, 1, 0, 0, 8'hFF); expect_byte("R11", 8'h00);
      send("R11", 5, 6, 0, 4'h1, 8'hFF); expect_byte("R11", 8'h01);
      wr(8'h40, 8'h00); wr(8'h3F, 8'h00);
      send("R11", 5, 6, 0, 4'h1, 8'hAA); expect_byte("R11", 8'h03);

      // sweep R3/R4/R5 over all channels with pseudo-random config
      for (int r = 0; r < 6; r++) begin
         for (int a = 8'h39; a <= 8'h40; a++) begin
            lcg = lcg * 1103515245 + 12345;
            wr(8'(a), lcg[23:16]);
         end
         for (int ch = 1; ch <= 24; ch++) begin
            for (int f = 6; f <= 24; f += 6) begin
               lcg = lcg * 1103515245 + 12345;
               send("R3 sweep", ch, f, lcg[3], lcg[7:4],
                    lcg[8] ? 8'h00 : lcg[31:24]);
            end
         end
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule